// File: doc/BRIEF.md
# AXI Single-Burst Write Engine

This block turns one command into one complete AXI write burst. A requester pulses a start strobe together with a transaction ID, a start address, a 4-bit length field, a beat size and a burst type. The engine then drives the address/control beat, streams the burst's data beats from a show-ahead FIFO-style feed, and collects the write response. When the response arrives it raises a one-cycle done pulse and reports the response code.

The three phases never overlap. Data starts only after the address handshake has completed. The response is awaited only after the final data beat has been accepted. Only one burst is in flight at a time, and a start strobe that arrives while a burst is active is dropped. Every output comes straight from a flop, so no path runs from an input pin to an output pin. The reset is asynchronous and active-low, and while it is asserted every output is zero.

The data feed presents its head word on `feed_data_i` and qualifies it with `feed_valid_i`. The engine copies a word into its W register and then pulses `feed_ack_o` for one cycle, which tells the feed to advance. Write strobes are always all ones, and only full-width, aligned beats are issued.

Top module: `axi_wr_engine`

## Requirements
- R1: While `rst_ni` is low, every output is 0, including `awvalid_o`, `wvalid_o`, `bready_o`, `feed_ack_o` and `done_o`. This holds immediately on assertion and independently of the clock.
- R2: A start strobe seen in the idle state causes `awvalid_o` to be high in the next cycle. At that point `awid_o`, `awaddr_o`, `awlen_o`, `awsize_o` and `awburst_o` carry the values captured at the start strobe, `awcache_o` carries the parameter value (default 4'b0011), `awprot_o` carries the parameter value (default 3'b000), and `awlock_o` is 0.
- R3: While `awvalid_o` is high and `awready_i` is low, `awvalid_o` and all address/control outputs stay unchanged. In the cycle after the address handshake, `awvalid_o` is low.
- R4: `wvalid_o` is never high before the address handshake of the same burst has completed.
- R5: A burst carries exactly `awlen_o`+1 data beats (length field 0..15 gives 1..16 beats). `wlast_o` is high on the final beat only, and `wstrb_o` is all ones whenever `wvalid_o` is high.
- R6: A presented beat keeps `wvalid_o`, `wdata_o` and `wlast_o` unchanged until a cycle with `wready_i` high. Beats carry the feed words in the order in which the feed presented them. `feed_ack_o` pulses once for each word taken.
- R7: `bready_o` rises only after the handshake that accepted the final data beat, and it stays high until `bvalid_i` is seen. In the cycle after the response handshake, `done_o` is high for exactly one cycle, `resp_o` holds the captured `bresp_i`, `bready_o` is low and the engine is idle again.
- R8: A start strobe that arrives while a burst is active has no effect. The current burst's address fields are unchanged, and no further address beat is issued after that burst completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted only while idle |
| cmd_id_i | input | ID_W | Transaction ID |
| cmd_addr_i | input | ADDR_W | Burst start address |
| cmd_len_i | input | 4 | Beats minus one |
| cmd_size_i | input | 3 | Beat size code |
| cmd_burst_i | input | 2 | Burst type code |
| feed_data_i | input | DATA_W | Head word of the data feed |
| feed_valid_i | input | 1 | Feed head word is valid |
| feed_ack_o | output | 1 | Head word taken, feed advances |
| done_o | output | 1 | One-cycle burst completion pulse |
| resp_o | output | 2 | Captured write response code |
| awid_o | output | ID_W | Write address ID |
| awaddr_o | output | ADDR_W | Write address |
| awlen_o | output | 4 | Burst length field |
| awsize_o | output | 3 | Beat size |
| awburst_o | output | 2 | Burst type |
| awcache_o | output | 4 | Cache attributes |
| awlock_o | output | 1 | Lock type, always 0 |
| awprot_o | output | 3 | Protection attributes |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | DATA_W | Write data |
| wstrb_o | output | DATA_W/8 | Write strobes |
| wlast_o | output | 1 | Final beat marker |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| bresp_i | input | 2 | Write response code |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |

## Verification
A corrupted beat counter shows up at the ports on the very beat it affects. `wlast_o` then lands early or late, or the beat total seen before the response differs from the length field plus one, and the bench compares both on every accepted beat. A wrong phase state shows up within one cycle as overlapping valids, an early `bready_o`, a missing or doubled done pulse, or a second address beat after an ignored start. Broken hold logic is caught in the first stalled cycle, because the bench compares each stalled output against its value in the previous cycle across sixteen lengths and four stall patterns.

// File: rtl/axi_wr_pkg.sv
package axi_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } wr_state_e;

  localparam int unsigned LEN_W  = 4;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned BRST_W = 2;
  localparam int unsigned RESP_W = 2;
endpackage

// File: rtl/axi_wr_aw_chan.sv
module axi_wr_aw_chan
  import axi_wr_pkg::*;
#(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter logic [3:0]  CACHE_V = 4'b0011,
  parameter logic [2:0]  PROT_V  = 3'b000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [BRST_W-1:0] burst_i,
  input  logic              awready_i,
  output logic [ID_W-1:0]   awid_o,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic [LEN_W-1:0]  awlen_o,
  output logic [SIZE_W-1:0] awsize_o,
  output logic [BRST_W-1:0] awburst_o,
  output logic [3:0]        awcache_o,
  output logic [2:0]        awprot_o,
  output logic              awvalid_o,
  output logic              fire_o
);
  assign fire_o = awvalid_o & awready_i;

  // fields stay put after the handshake; the data phase reads awlen_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      awid_o    <= '0;
      awaddr_o  <= '0;
      awlen_o   <= '0;
      awsize_o  <= '0;
      awburst_o <= '0;
      awcache_o <= '0;
      awprot_o  <= '0;
      awvalid_o <= 1'b0;
    end else if (load_i) begin
      awid_o    <= id_i;
      awaddr_o  <= addr_i;
      awlen_o   <= len_i;
      awsize_o  <= size_i;
      awburst_o <= burst_i;
      awcache_o <= CACHE_V;
      awprot_o  <= PROT_V;
      awvalid_o <= 1'b1;
    end else if (fire_o) begin
      awvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/axi_wr_w_chan.sv
module axi_wr_w_chan
  import axi_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] feed_data_i,
  input  logic              feed_valid_i,
  input  logic              wready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] wstrb_o,
  output logic              wlast_o,
  output logic              wvalid_o,
  output logic              feed_ack_o,
  output logic              last_fire_o
);
  logic [LEN_W-1:0] beat_q;
  logic             load, fire;

  // skip the cycle where ack is out: the feed head is still the old word
  assign load        = en_i & ~wvalid_o & ~feed_ack_o & feed_valid_i;
  assign fire        = wvalid_o & wready_i;
  assign last_fire_o = fire & wlast_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_o    <= '0;
      wstrb_o    <= '0;
      wlast_o    <= 1'b0;
      wvalid_o   <= 1'b0;
      feed_ack_o <= 1'b0;
    end else begin
      feed_ack_o <= load;
      if (load) begin
        wdata_o  <= feed_data_i;
        wstrb_o  <= '1;
        wlast_o  <= (beat_q == len_i);
        wvalid_o <= 1'b1;
      end else if (fire) begin
        wdata_o  <= '0;
        wstrb_o  <= '0;
        wlast_o  <= 1'b0;
        wvalid_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               beat_q <= '0;
    else if (!en_i)            beat_q <= '0;
    else if (fire && !wlast_o) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/axi_wr_b_chan.sv
module axi_wr_b_chan
  import axi_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              bvalid_i,
  input  logic [RESP_W-1:0] bresp_i,
  output logic              bready_o,
  output logic              done_o,
  output logic [RESP_W-1:0] resp_o,
  output logic              fire_o
);
  assign fire_o = bready_o & bvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bready_o <= 1'b0;
      done_o   <= 1'b0;
      resp_o   <= '0;
    end else begin
      done_o <= fire_o;
      if (arm_i)       bready_o <= 1'b1;
      else if (fire_o) bready_o <= 1'b0;
      if (fire_o)      resp_o   <= bresp_i;
    end
  end
endmodule

// File: rtl/axi_wr_engine.sv
module axi_wr_engine
  import axi_wr_pkg::*;
#(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter logic [3:0]  CACHE_V = 4'b0011,
  parameter logic [2:0]  PROT_V  = 3'b000,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [3:0]        cmd_len_i,
  input  logic [2:0]        cmd_size_i,
  input  logic [1:0]        cmd_burst_i,
  input  logic [DATA_W-1:0] feed_data_i,
  input  logic              feed_valid_i,
  output logic              feed_ack_o,
  output logic              done_o,
  output logic [1:0]        resp_o,
  output logic [ID_W-1:0]   awid_o,
  output logic [ADDR_W-1:0] awaddr_o,
  output logic [3:0]        awlen_o,
  output logic [2:0]        awsize_o,
  output logic [1:0]        awburst_o,
  output logic [3:0]        awcache_o,
  output logic              awlock_o,
  output logic [2:0]        awprot_o,
  output logic              awvalid_o,
  input  logic              awready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STRB_W-1:0] wstrb_o,
  output logic              wlast_o,
  output logic              wvalid_o,
  input  logic              wready_i,
  input  logic [1:0]        bresp_i,
  input  logic              bvalid_i,
  output logic              bready_o
);
  wr_state_e state_q, state_d;
  logic      load, aw_fire, w_last_fire, b_fire;

  assign load     = start_i & (state_q == ST_IDLE);
  assign awlock_o = 1'b0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)     state_d = ST_ADDR;
      ST_ADDR: if (aw_fire)     state_d = ST_DATA;
      ST_DATA: if (w_last_fire) state_d = ST_RESP;
      ST_RESP: if (b_fire)      state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  axi_wr_aw_chan #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .CACHE_V(CACHE_V), .PROT_V(PROT_V)
  ) u_aw (
    .clk_i, .rst_ni,
    .load_i    (load),
    .id_i      (cmd_id_i),
    .addr_i    (cmd_addr_i),
    .len_i     (cmd_len_i),
    .size_i    (cmd_size_i),
    .burst_i   (cmd_burst_i),
    .awready_i,
    .awid_o, .awaddr_o, .awlen_o, .awsize_o, .awburst_o,
    .awcache_o, .awprot_o, .awvalid_o,
    .fire_o    (aw_fire)
  );

  axi_wr_w_chan #(.DATA_W(DATA_W)) u_w (
    .clk_i, .rst_ni,
    .en_i        (state_q == ST_DATA),
    .len_i       (awlen_o),
    .feed_data_i, .feed_valid_i, .wready_i,
    .wdata_o, .wstrb_o, .wlast_o, .wvalid_o, .feed_ack_o,
    .last_fire_o (w_last_fire)
  );

  axi_wr_b_chan u_b (
    .clk_i, .rst_ni,
    .arm_i    (w_last_fire),
    .bvalid_i, .bresp_i,
    .bready_o, .done_o, .resp_o,
    .fire_o   (b_fire)
  );
endmodule

// File: rtl/axi_wr_engine_chk.sv
module axi_wr_engine_chk #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              feed_ack_o,
  input logic              done_o,
  input logic [ID_W-1:0]   awid_o,
  input logic [ADDR_W-1:0] awaddr_o,
  input logic [3:0]        awlen_o,
  input logic [2:0]        awsize_o,
  input logic              awvalid_o,
  input logic              awready_i,
  input logic [DATA_W-1:0] wdata_o,
  input logic [STRB_W-1:0] wstrb_o,
  input logic              wlast_o,
  input logic              wvalid_o,
  input logic              wready_i,
  input logic              bvalid_i,
  input logic              bready_o
);
  logic [4:0] beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   beats_q <= '0;
    else if (awvalid_o && awready_i) beats_q <= '0;
    else if (wvalid_o && wready_i)   beats_q <= beats_q + 5'd1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_quiet_r1: assert (!awvalid_o && !wvalid_o && !bready_o && !feed_ack_o && !done_o);
    end
  end

  p_aw_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o) && $stable(awid_o)
                               && $stable(awlen_o) && $stable(awsize_o));

  p_aw_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && awready_i |=> !awvalid_o);

  p_aw_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o |-> !awvalid_o);

  p_last_beat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && wready_i && wlast_o |-> beats_q == {1'b0, awlen_o});

  p_mid_beat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wlast_o |-> beats_q < {1'b0, awlen_o});

  p_full_strb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o |-> &wstrb_o);

  p_w_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wready_i |=> wvalid_o && $stable(wdata_o) && $stable(wlast_o));

  p_bready_late_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bready_o) |-> $past(wvalid_o && wready_i && wlast_o));

  p_bready_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bready_o && !bvalid_i |=> bready_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bvalid_i && bready_o));

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (awvalid_o || wvalid_o || bready_o) |=> $stable(awaddr_o) && $stable(awid_o));
endmodule

bind axi_wr_engine axi_wr_engine_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .feed_ack_o(feed_ack_o),
  .done_o(done_o), .awid_o(awid_o), .awaddr_o(awaddr_o), .awlen_o(awlen_o),
  .awsize_o(awsize_o), .awvalid_o(awvalid_o), .awready_i(awready_i),
  .wdata_o(wdata_o), .wstrb_o(wstrb_o), .wlast_o(wlast_o), .wvalid_o(wvalid_o),
  .wready_i(wready_i), .bvalid_i(bvalid_i), .bready_o(bready_o)
);

// File: tb/axi_wr_engine_tb.sv
module axi_wr_engine_tb;
  localparam int ID_W = 4, ADDR_W = 16, DATA_W = 16, STRB_W = DATA_W / 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ID_W-1:0]   cmd_id_i = '0;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic [3:0]        cmd_len_i = '0;
  logic [2:0]        cmd_size_i = '0;
  logic [1:0]        cmd_burst_i = '0;
  logic [DATA_W-1:0] feed_data_i = '0;
  logic feed_valid_i = 1'b0, feed_ack_o, done_o;
  logic [1:0] resp_o;
  logic [ID_W-1:0] awid_o;
  logic [ADDR_W-1:0] awaddr_o;
  logic [3:0] awlen_o, awcache_o;
  logic [2:0] awsize_o, awprot_o;
  logic [1:0] awburst_o;
  logic awlock_o, awvalid_o, awready_i = 1'b0;
  logic [DATA_W-1:0] wdata_o;
  logic [STRB_W-1:0] wstrb_o;
  logic wlast_o, wvalid_o, wready_i = 1'b0;
  logic [1:0] bresp_i = '0;
  logic bvalid_i = 1'b0, bready_o;

  int n_tests = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  axi_wr_engine #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit rdy(input int pat, input int c);
    case (pat)
      0:       return 1'b1;
      1:       return c[0];
      2:       return (c % 3) == 2;
      default: return (c % 4) == 3;
    endcase
  endfunction

  task automatic chk_quiet(input string tag);
    chk(!awvalid_o && !wvalid_o && !bready_o && !feed_ack_o && !done_o, tag,
        {awvalid_o, wvalid_o, bready_o, feed_ack_o, done_o}, 0);
    chk(awaddr_o == 0 && wdata_o == 0 && wstrb_o == 0 && !wlast_o && resp_o == 0,
        {tag, " fields"}, awaddr_o, 0);
  endtask

  task automatic run_burst(input int len, input int pat, input logic [1:0] rsp);
    logic [ADDR_W-1:0] exp_addr = ADDR_W'(16'h1000 + len * 64 + pat * 8);
    logic [ID_W-1:0]   exp_id   = ID_W'(len ^ pat);
    logic [DATA_W-1:0] base     = DATA_W'(len * 256 + pat * 32);
    logic [DATA_W-1:0] prev_wdata = '0;
    int  head = 0, beats = 0, aw_fires = 0, bwait = 0;
    bit  aw_pred = 0, aw_stall = 0, aw_done = 0, w_stall = 0, prev_wlast = 0;
    bit  last_done = 0, b_pred = 0, done_seen = 0, bready_bad = 0;

    @(negedge clk_i);
    start_i = 1'b1; cmd_id_i = exp_id; cmd_addr_i = exp_addr;
    cmd_len_i = 4'(len); cmd_size_i = 3'd1; cmd_burst_i = 2'd1;
    feed_data_i = base; feed_valid_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; cmd_addr_i = ~exp_addr; cmd_id_i = ~exp_id; cmd_len_i = ~cmd_len_i;
    chk(awvalid_o, "R2 awvalid after start", awvalid_o, 1);
    chk(awid_o == exp_id && awaddr_o == exp_addr && awlen_o == 4'(len), "R2 id/addr/len",
        awaddr_o, exp_addr);
    chk(awsize_o == 3'd1 && awburst_o == 2'd1 && awcache_o == 4'b0011 &&
        awprot_o == 3'b000 && !awlock_o, "R2 attributes",
        {awsize_o, awburst_o, awcache_o, awprot_o, awlock_o}, {3'd1, 2'd1, 4'b0011, 3'd0, 1'b0});

    for (int c = 0; c < 600; c++) begin
      if (aw_pred) begin
        chk(!awvalid_o, "R3 awvalid drops after handshake", awvalid_o, 0);
        aw_pred = 0;
      end
      if (aw_stall)
        chk(awvalid_o && awaddr_o == exp_addr && awid_o == exp_id && awlen_o == 4'(len),
            "R3 address held on stall", awaddr_o, exp_addr);
      if (w_stall)
        chk(wvalid_o && wdata_o == prev_wdata && wlast_o == prev_wlast,
            "R6 beat held on stall", wdata_o, prev_wdata);
      if (wvalid_o) chk(aw_done, "R4 data before address handshake", wvalid_o, 0);
      if (bready_o && !last_done && !bready_bad) begin
        bready_bad = 1;
        chk(0, "R7 bready before last beat", 1, 0);
      end
      if (b_pred) begin
        chk(done_o && resp_o == rsp, "R7 done pulse and response", {done_o, resp_o}, {1'b1, rsp});
        chk(!bready_o, "R7 bready cleared", bready_o, 0);
        chk(beats == len + 1, "R5 beat total", beats, len + 1);
        done_seen = 1;
        bvalid_i = 1'b0;
        @(negedge clk_i);
        chk(!done_o, "R7 done lasts one cycle", done_o, 0);
        break;
      end
      if (done_o) chk(0, "R7 early done", 1, 0);

      if (feed_ack_o) head++;
      feed_data_i  = base + DATA_W'(head);
      feed_valid_i = rdy(pat, c + 1);

      start_i = (pat == 3 && c == 2);
      if (start_i) begin cmd_addr_i = ~exp_addr; cmd_id_i = ~exp_id; end

      awready_i = rdy(pat, c);
      wready_i  = rdy(pat, c + 2);

      if (bready_o && !bvalid_i) begin
        if (bwait >= pat) begin bvalid_i = 1'b1; bresp_i = rsp; end
        else bwait++;
      end

      aw_stall = awvalid_o && !awready_i;
      if (awvalid_o && awready_i) begin aw_pred = 1; aw_done = 1; aw_fires++; end
      w_stall = wvalid_o && !wready_i;
      prev_wdata = wdata_o;
      prev_wlast = wlast_o;
      if (wvalid_o && wready_i) begin
        chk(wdata_o == base + DATA_W'(beats), "R6 data order", wdata_o, base + DATA_W'(beats));
        chk(wlast_o == (beats == len), "R5 wlast placement", wlast_o, beats == len);
        chk(wstrb_o == '1, "R5 full strobes", wstrb_o, {STRB_W{1'b1}});
        beats++;
        if (wlast_o) last_done = 1;
      end
      if (bvalid_i && bready_o) b_pred = 1;
      @(negedge clk_i);
    end
    start_i = 1'b0; feed_valid_i = 1'b0; awready_i = 1'b0; wready_i = 1'b0; bvalid_i = 1'b0;
    if (!done_seen) chk(0, "R7 burst never completed", 0, 1);
    chk(head == len + 1, "R6 feed acks per burst", head, len + 1);
    chk(aw_fires == 1, "R8 single address beat", aw_fires, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!awvalid_o, "R8 ignored start not replayed", awvalid_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_quiet("R1 outputs zero in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_quiet("R1 idle after reset");

    for (int len = 0; len < 16; len++)
      for (int pat = 0; pat < 4; pat++)
        run_burst(len, pat, 2'((len + pat) % 4));

    // reset in the middle of a data phase
    @(negedge clk_i);
    start_i = 1'b1; cmd_addr_i = 16'h2000; cmd_len_i = 4'd7; cmd_id_i = 4'd5;
    @(negedge clk_i);
    start_i = 1'b0; awready_i = 1'b1; feed_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(wvalid_o || feed_ack_o, "R1 burst in progress before reset", wvalid_o, 1);
    rst_ni = 1'b0;
    #1;
    chk_quiet("R1 asynchronous clear mid-burst");
    awready_i = 1'b0; feed_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_quiet("R1 held clear while reset low");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_quiet("R1 idle after second reset");
    run_burst(9, 2, 2'd2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule